// File: doc/BRIEF.md
# Pooled Physical Register Rename Map

This block maps a small set of architected registers onto one shared pool of physical registers. Every pool entry stores a data word, a busy flag (the entry is owned by some mapping) and a valid flag (its data has been produced). Two pointer tables sit in front of the pool. The committed table gives, for each architected register, the physical entry that holds its in-order value. The speculative table gives the newest mapping made at dispatch, and each of its entries has its own valid flag.

Dispatch reads operands by architected number: the speculative pointer is used when valid, otherwise the committed one. A produced value comes back as ready data; otherwise the physical index is returned as a wait tag. Dispatch also claims the lowest-numbered free entry for a destination and records it in the speculative table. Execution writes results by physical index. Commit, driven in order from the reorder-buffer head, only moves pointers: the committed table is redirected to the new entry and the entry it used to name is released. A mispredict flush drops every speculative mapping and returns every busy entry that the committed table does not name to the free pool.

Top module: `rn_pool_map`

## Requirements
- R1: After reset, architected register i maps to physical entry i, entries 0 to NUM_ARCH-1 are busy and valid with data 0, all other entries are free, and no speculative mapping is valid.
- R2: An operand lookup uses the speculative pointer of the architected register when that pointer is valid and the committed pointer otherwise; src_tag always shows the chosen physical index.
- R3: When the chosen entry is valid, src_ready is 1 and src_data carries its data; otherwise src_ready is 0 and src_data is 0.
- R4: An allocation request is granted when any entry is free; alloc_phys is the lowest-numbered free entry, which becomes busy and not valid from the next cycle.
- R5: A granted allocation sets the speculative pointer of alloc_arch to alloc_phys and marks it valid.
- R6: A writeback stores wb_data into entry wb_phys and marks it valid; lookups see the new value from the next cycle on.
- R7: A commit whose entry cmt_phys is not valid raises cmt_stall in the same cycle and changes no pointer.
- R8: A commit whose entry is valid points the committed table entry of cmt_arch at cmt_phys and frees the entry that table entry named before.
- R9: A flush clears the valid flag of every speculative pointer, so lookups return to the committed mapping.
- R10: A flush frees every busy entry that the committed table does not name, leaving exactly NUM_ARCH busy entries.
- R11: An allocation request while no entry is free raises alloc_stall and changes no state; an entry freed by a commit in the same cycle can be claimed from the next cycle.
- R12: During a flush no allocation is granted; a commit in the same cycle still applies, and the flush reclaim is judged against the updated committed table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_arch | input | NUM_SRC*AW | Architected register of each operand lookup |
| src_ready | output | NUM_SRC | Operand value is available |
| src_data | output | NUM_SRC*DATA_W | Operand value, 0 when not ready |
| src_tag | output | NUM_SRC*PW | Physical index chosen for each operand |
| alloc_req | input | 1 | Destination allocation request |
| alloc_arch | input | AW | Destination architected register |
| alloc_grant | output | 1 | Allocation takes place this cycle |
| alloc_stall | output | 1 | Request not served this cycle |
| alloc_phys | output | PW | Lowest free physical entry |
| wb_valid | input | 1 | Result writeback strobe |
| wb_phys | input | PW | Physical entry written |
| wb_data | input | DATA_W | Result value |
| cmt_valid | input | 1 | Commit request from the reorder-buffer head |
| cmt_arch | input | AW | Architected register being committed |
| cmt_phys | input | PW | Physical entry being committed |
| cmt_stall | output | 1 | Commit cannot complete this cycle |
| flush | input | 1 | Mispredict recovery |

## Verification
The cycles of interest are those where a commit and an allocation land together: with the pool full, the commit releases an entry while the allocation request in that same cycle must still stall, and the released entry must be the one granted a cycle later. The bench provokes this with a directed sequence that fills the pool, and it judges every cycle against a bench-side model of both tables and the pool built from the requirements. A commit arriving together with a flush is provoked the same way, and a long pseudo-random phase with an in-order commit queue mixes all four functions.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int unsigned RN_NUM_ARCH = 8;
    localparam int unsigned RN_NUM_PHYS = 16;
    localparam int unsigned RN_DATA_W   = 32;
    localparam int unsigned RN_NUM_SRC  = 2;

    // index width for a table of n entries, never below one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
    parameter int unsigned NUM_PHYS = 16,
    parameter int unsigned PW       = 4
) (
    input  logic [NUM_PHYS-1:0] busy,
    output logic                any_free,
    output logic [PW-1:0]       free_idx
);

    // scan downward so the lowest free index is the one that survives
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = PW'(i);
            end
        end
    end

endmodule

// File: rtl/rn_ref_mask.sv
module rn_ref_mask #(
    parameter int unsigned NUM_ARCH = 8,
    parameter int unsigned NUM_PHYS = 16,
    parameter int unsigned PW       = 4
) (
    input  logic [NUM_ARCH-1:0][PW-1:0] arp,
    output logic [NUM_PHYS-1:0]         ref_mask
);

    // one comparator row per physical entry: is it named by any committed pointer
    for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int a = 0; a < NUM_ARCH; a++) begin
                if (arp[a] == PW'(p)) hit = 1'b1;
            end
        end
        assign ref_mask[p] = hit;
    end

endmodule

// File: rtl/rn_src_port.sv
module rn_src_port #(
    parameter int unsigned NUM_ARCH = 8,
    parameter int unsigned NUM_PHYS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned AW       = 3,
    parameter int unsigned PW       = 4
) (
    input  logic [AW-1:0]                   arch,
    input  logic [NUM_ARCH-1:0][PW-1:0]     arp,
    input  logic [NUM_ARCH-1:0][PW-1:0]     rrp,
    input  logic [NUM_ARCH-1:0]             rrp_vld,
    input  logic [NUM_PHYS-1:0]             vld,
    input  logic [NUM_PHYS-1:0][DATA_W-1:0] data,
    output logic                            ready,
    output logic [DATA_W-1:0]               value,
    output logic [PW-1:0]                   tag
);

    logic [PW-1:0] sel;

    always_comb begin
        sel   = rrp_vld[arch] ? rrp[arch] : arp[arch];
        tag   = sel;
        ready = vld[sel];
        value = vld[sel] ? data[sel] : '0;
    end

endmodule

// File: rtl/rn_pool_map.sv
module rn_pool_map
    import rn_pkg::*;
#(
    parameter  int unsigned NUM_ARCH = RN_NUM_ARCH,
    parameter  int unsigned NUM_PHYS = RN_NUM_PHYS,
    parameter  int unsigned DATA_W   = RN_DATA_W,
    parameter  int unsigned NUM_SRC  = RN_NUM_SRC,
    localparam int unsigned AW       = idx_w(NUM_ARCH),
    localparam int unsigned PW       = idx_w(NUM_PHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC*AW-1:0]     src_arch,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic [NUM_SRC*DATA_W-1:0] src_data,
    output logic [NUM_SRC*PW-1:0]     src_tag,
    input  logic                      alloc_req,
    input  logic [AW-1:0]             alloc_arch,
    output logic                      alloc_grant,
    output logic                      alloc_stall,
    output logic [PW-1:0]             alloc_phys,
    input  logic                      wb_valid,
    input  logic [PW-1:0]             wb_phys,
    input  logic [DATA_W-1:0]         wb_data,
    input  logic                      cmt_valid,
    input  logic [AW-1:0]             cmt_arch,
    input  logic [PW-1:0]             cmt_phys,
    output logic                      cmt_stall,
    input  logic                      flush
);

    typedef struct packed {
        logic [NUM_PHYS-1:0][DATA_W-1:0] data;
        logic [NUM_PHYS-1:0]             busy;
        logic [NUM_PHYS-1:0]             vld;
        logic [NUM_ARCH-1:0][PW-1:0]     arp;
        logic [NUM_ARCH-1:0][PW-1:0]     rrp;
        logic [NUM_ARCH-1:0]             rrp_vld;
    } map_state_t;

    function automatic map_state_t reset_state();
        map_state_t s;
        s = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            s.arp[i]  = PW'(i);
            s.busy[i] = 1'b1;
            s.vld[i]  = 1'b1;
        end
        return s;
    endfunction

    map_state_t s_q, s_d;

    logic                        any_free;
    logic [PW-1:0]               free_idx;
    logic                        commit_ok;
    logic [PW-1:0]               old_phys;
    logic [NUM_ARCH-1:0][PW-1:0] arp_post;
    logic [NUM_PHYS-1:0]         arp_ref;

    // flat views of the state for the bound checker
    logic [NUM_PHYS-1:0]         busy_q;
    logic [NUM_PHYS-1:0]         vld_q;
    logic [NUM_ARCH-1:0][PW-1:0] arp_q;
    logic [NUM_ARCH-1:0]         rrp_vld_q;

    assign busy_q    = s_q.busy;
    assign vld_q     = s_q.vld;
    assign arp_q     = s_q.arp;
    assign rrp_vld_q = s_q.rrp_vld;

    rn_free_pick #(
        .NUM_PHYS (NUM_PHYS),
        .PW       (PW)
    ) u_free_pick (
        .busy     (s_q.busy),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    // committed table as it stands after this cycle's commit
    always_comb begin
        commit_ok = cmt_valid && s_q.vld[cmt_phys];
        old_phys  = s_q.arp[cmt_arch];
        arp_post  = s_q.arp;
        if (commit_ok) arp_post[cmt_arch] = cmt_phys;
    end

    rn_ref_mask #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .PW       (PW)
    ) u_ref_mask (
        .arp      (arp_post),
        .ref_mask (arp_ref)
    );

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        rn_src_port #(
            .NUM_ARCH (NUM_ARCH),
            .NUM_PHYS (NUM_PHYS),
            .DATA_W   (DATA_W),
            .AW       (AW),
            .PW       (PW)
        ) u_src (
            .arch     (src_arch[k*AW +: AW]),
            .arp      (s_q.arp),
            .rrp      (s_q.rrp),
            .rrp_vld  (s_q.rrp_vld),
            .vld      (s_q.vld),
            .data     (s_q.data),
            .ready    (src_ready[k]),
            .value    (src_data[k*DATA_W +: DATA_W]),
            .tag      (src_tag[k*PW +: PW])
        );
    end

    assign alloc_grant = alloc_req && any_free && !flush;
    assign alloc_stall = alloc_req && !alloc_grant;
    assign alloc_phys  = free_idx;
    assign cmt_stall   = cmt_valid && !commit_ok;

    always_comb begin
        s_d     = s_q;
        s_d.arp = arp_post;

        // commit: release the entry the committed pointer used to name
        if (commit_ok && (old_phys != cmt_phys)) begin
            s_d.busy[old_phys] = 1'b0;
        end

        // result writeback
        if (wb_valid) begin
            s_d.data[wb_phys] = wb_data;
            s_d.vld[wb_phys]  = 1'b1;
        end

        if (flush) begin
            s_d.rrp_vld = '0;
            s_d.busy    = s_d.busy & arp_ref;
        end else if (alloc_grant) begin
            s_d.busy[free_idx]        = 1'b1;
            s_d.vld[free_idx]         = 1'b0;
            s_d.rrp[alloc_arch]       = free_idx;
            s_d.rrp_vld[alloc_arch]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rn_pool_map_chk.sv
module rn_pool_map_chk #(
    parameter  int unsigned NUM_ARCH = 8,
    parameter  int unsigned NUM_PHYS = 16,
    localparam int unsigned AW       = rn_pkg::idx_w(NUM_ARCH),
    localparam int unsigned PW       = rn_pkg::idx_w(NUM_PHYS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        alloc_grant,
    input logic                        alloc_stall,
    input logic [PW-1:0]               alloc_phys,
    input logic                        wb_valid,
    input logic [PW-1:0]               wb_phys,
    input logic                        cmt_valid,
    input logic                        cmt_stall,
    input logic [AW-1:0]               cmt_arch,
    input logic [PW-1:0]               cmt_phys,
    input logic                        flush,
    input logic [NUM_PHYS-1:0]         busy,
    input logic [NUM_PHYS-1:0]         vld,
    input logic [NUM_ARCH-1:0][PW-1:0] arp,
    input logic [NUM_ARCH-1:0]         rrp_vld
);

    // R4
    alloc_claims_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> busy[$past(alloc_phys)] && !vld[$past(alloc_phys)]);

    // R6
    wb_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(alloc_grant && alloc_phys == wb_phys)) |=> vld[$past(wb_phys)]);

    // R7
    stalled_commit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_stall |=> $stable(arp));

    // R8
    commit_moves_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !cmt_stall) |=> arp[$past(cmt_arch)] == $past(cmt_phys));

    // R9
    flush_drops_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> rrp_vld == '0);

    // R10
    flush_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $countones(busy) == NUM_ARCH);

    // R11
    stall_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_stall && !flush) |-> (&busy));

endmodule

bind rn_pool_map rn_pool_map_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_grant (alloc_grant),
    .alloc_stall (alloc_stall),
    .alloc_phys  (alloc_phys),
    .wb_valid    (wb_valid),
    .wb_phys     (wb_phys),
    .cmt_valid   (cmt_valid),
    .cmt_stall   (cmt_stall),
    .cmt_arch    (cmt_arch),
    .cmt_phys    (cmt_phys),
    .flush       (flush),
    .busy        (busy_q),
    .vld         (vld_q),
    .arp         (arp_q),
    .rrp_vld     (rrp_vld_q)
);

// File: tb/rn_pool_map_tb.sv
`timescale 1ns/1ps
module rn_pool_map_tb;

    localparam int NA = 8;
    localparam int NP = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    src_arch = '0;
    logic [1:0]    src_ready;
    logic [63:0]   src_data;
    logic [7:0]    src_tag;
    logic          alloc_req = 1'b0;
    logic [2:0]    alloc_arch = '0;
    logic          alloc_grant, alloc_stall;
    logic [3:0]    alloc_phys;
    logic          wb_valid = 1'b0;
    logic [3:0]    wb_phys = '0;
    logic [31:0]   wb_data = '0;
    logic          cmt_valid = 1'b0;
    logic [2:0]    cmt_arch = '0;
    logic [3:0]    cmt_phys = '0;
    logic          cmt_stall;
    logic          flush = 1'b0;

    always #10 clk = ~clk;

    rn_pool_map u_dut (
        .clk, .rst_n, .src_arch, .src_ready, .src_data, .src_tag,
        .alloc_req, .alloc_arch, .alloc_grant, .alloc_stall, .alloc_phys,
        .wb_valid, .wb_phys, .wb_data, .cmt_valid, .cmt_arch, .cmt_phys,
        .cmt_stall, .flush
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the tables, built from the requirements
    logic [31:0] data_m [NP];
    bit          busy_m [NP];
    bit          vld_m  [NP];
    int          arp_m  [NA];
    int          rrp_m  [NA];
    bit          rrpv_m [NA];
    bit          g_grant;
    int          g_phys;
    bit          g_cok;

    // in-order commit queue for the random phase
    int fq_a [16];
    int fq_p [16];
    int fq_head = 0;
    int fq_cnt  = 0;

    task automatic model_reset();
        for (int p = 0; p < NP; p++) begin
            data_m[p] = '0;
            busy_m[p] = (p < NA);
            vld_m[p]  = (p < NA);
        end
        for (int a = 0; a < NA; a++) begin
            arp_m[a] = a; rrp_m[a] = 0; rrpv_m[a] = 0;
        end
    endtask

    task automatic chk_src(input int port, input int a, input string r);
        int sel; bit er; logic [31:0] ed;
        sel = rrpv_m[a] ? rrp_m[a] : arp_m[a];
        er  = vld_m[sel];
        ed  = er ? data_m[sel] : 32'd0;
        checks++;
        if (src_ready[port] !== er || src_tag[port*4 +: 4] !== 4'(sel) ||
            src_data[port*32 +: 32] !== ed) begin
            fails++;
            $display("FAIL %s lookup arch %0d: got rdy=%0b tag=%0d data=%h, exp rdy=%0b tag=%0d data=%h",
                     r, a, src_ready[port], src_tag[port*4 +: 4], src_data[port*32 +: 32], er, sel, ed);
        end
    endtask

    task automatic step(input bit ar, input int aa, input bit wv, input int wp,
                        input logic [31:0] wd, input bit cv, input int ca, input int cp,
                        input bit fl, input int s0, input int s1, input string r);
        int free; bit any; int old; bit refd;
        alloc_req = ar; alloc_arch = 3'(aa);
        wb_valid = wv; wb_phys = 4'(wp); wb_data = wd;
        cmt_valid = cv; cmt_arch = 3'(ca); cmt_phys = 4'(cp);
        flush = fl; src_arch = {3'(s1), 3'(s0)};
        #2;
        any = 0; free = 0;
        for (int p = NP - 1; p >= 0; p--) if (!busy_m[p]) begin any = 1; free = p; end
        g_grant = ar && any && !fl;
        g_phys  = free;
        g_cok   = cv && vld_m[cp];
        chk_src(0, s0, r);
        chk_src(1, s1, r);
        if (ar) begin
            checks++;
            if (g_grant && (alloc_grant !== 1'b1 || alloc_stall !== 1'b0 || alloc_phys !== 4'(free))) begin
                fails++;
                $display("FAIL R4 alloc: got grant=%0b phys=%0d, exp grant=1 phys=%0d",
                         alloc_grant, alloc_phys, free);
            end else if (!g_grant && (alloc_grant !== 1'b0 || alloc_stall !== 1'b1)) begin
                fails++;
                $display("FAIL %s alloc stall: got grant=%0b stall=%0b, exp grant=0 stall=1",
                         fl ? "R12" : "R11", alloc_grant, alloc_stall);
            end
        end
        if (cv) begin
            checks++;
            if (cmt_stall !== !g_cok) begin
                fails++;
                $display("FAIL R7 commit stall: got %0b exp %0b", cmt_stall, !g_cok);
            end
        end
        @(posedge clk);
        if (g_cok) begin
            old = arp_m[ca];
            arp_m[ca] = cp;
            if (old != cp) busy_m[old] = 0;
        end
        if (wv) begin data_m[wp] = wd; vld_m[wp] = 1; end
        if (fl) begin
            for (int a = 0; a < NA; a++) rrpv_m[a] = 0;
            for (int p = 0; p < NP; p++) begin
                refd = 0;
                for (int a = 0; a < NA; a++) if (arp_m[a] == p) refd = 1;
                if (!refd) busy_m[p] = 0;
            end
        end else if (g_grant) begin
            busy_m[free] = 1; vld_m[free] = 0;
            rrp_m[aa] = free; rrpv_m[aa] = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle_look(input int s0, input int s1, input string r);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, s0, s1, r);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, exp completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping, every architected register on both ports
        for (int a = 0; a < NA; a++) idle_look(a, NA - 1 - a, "R1");

        // R4: fill the pool, one destination per architected register
        for (int a = 0; a < NA; a++) step(1, a, 0, 0, 0, 0, 0, 0, 0, a, (a + 3) % NA, "R4");
        // R5: every lookup now follows the speculative pointer, not ready
        for (int a = 0; a < NA; a += 2) idle_look(a, a + 1, "R5");
        // R11: pool empty
        step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11");

        // R6: results for the even registers
        for (int a = 0; a < NA; a += 2)
            step(0, 0, 1, 8 + a, 32'hC0DE_0000 + 32'(a * 7), 0, 0, 0, 0, a, a + 1, "R6");
        for (int a = 0; a < NA; a += 2) idle_look(a, a + 1, "R6");

        // R8: commit frees entry 0, which the next allocation reuses
        step(0, 0, 0, 0, 0, 1, 0, 8, 0, 0, 3, "R8");
        step(1, 3, 0, 0, 0, 0, 0, 0, 0, 3, 0, "R8");
        // R11: commit and allocation in one cycle with the pool full
        step(1, 5, 0, 0, 0, 1, 2, 10, 0, 2, 5, "R11");
        step(1, 5, 0, 0, 0, 0, 0, 0, 0, 5, 2, "R11");
        // R7: commit of an entry written only in this same cycle
        step(0, 0, 1, 9, 32'h0000_BEEF, 1, 1, 9, 0, 1, 0, "R7");
        step(0, 0, 0, 0, 0, 1, 1, 9, 0, 1, 3, "R8");

        // R12: flush with a commit and an allocation request in the same cycle
        step(1, 6, 0, 0, 0, 1, 4, 12, 1, 4, 6, "R12");
        // R9: lookups back on the committed mapping
        for (int a = 0; a < NA; a += 2) idle_look(a, a + 1, "R9");
        // R10: reclaimed entries come back in ascending order
        for (int k = 0; k < NP - NA + 1; k++) step(1, k % NA, 0, 0, 0, 0, 0, 0, 0, k % NA, 7, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R9");

        // R2: pseudo-random mix with an in-order commit queue
        for (int n = 0; n < 3000; n++) begin
            bit ar, wv, cv, fl; int aa, wp, ca, cp;
            ar = ($urandom % 3) != 0; aa = $urandom % NA;
            wv = 0; wp = 0; cv = 0; ca = 0; cp = 0;
            if (fq_cnt > 0 && ($urandom % 2) == 1) begin
                wp = fq_p[(fq_head + ($urandom % fq_cnt)) % 16];
                wv = !vld_m[wp];
            end
            if (fq_cnt > 0 && ($urandom % 2) == 1) begin
                cv = 1; ca = fq_a[fq_head]; cp = fq_p[fq_head];
            end
            fl = ($urandom % 60) == 0;
            step(ar, aa, wv, wp, $urandom, cv, ca, cp, fl, $urandom % NA, $urandom % NA, "R2");
            if (g_cok) begin fq_head = (fq_head + 1) % 16; fq_cnt--; end
            if (fl) fq_cnt = 0;
            else if (g_grant) begin
                fq_a[(fq_head + fq_cnt) % 16] = aa;
                fq_p[(fq_head + fq_cnt) % 16] = g_phys;
                fq_cnt++;
            end
        end

        // R3: final sweep of every register
        for (int a = 0; a < NA; a++) idle_look(a, NA - 1 - a, "R3");
        finish_run();
    end

endmodule